// File: doc/BRIEF.md
# Recursive Divide-and-Conquer Squarer

This unit is purely combinational. It takes an unsigned operand of W bits and returns its square on 2W bits. The operand is split into a high half and a low half. Each half is squared by a squarer of half the width, built the same way, and the two halves are multiplied once by a half-width multiplier. The cross product is doubled by wiring it one place to the left, with no adder. Two short additions then join the three terms. The recursion ends in a 2-bit squarer built from one AND gate and one half adder. The half-width multiplier follows the same recursive pattern and ends in a 2x2 cell made of AND gates and two half adders.

The block fits in a datapath wherever a value must be squared within one combinational stage, for example in magnitude or energy estimates and in transform kernels. W is a parameter and must be a power of two between 4 and 32. Any other value stops elaboration with an error message.

Top module: `dc_squarer`

## Requirements
- R1: For every operand value, `sq_o` equals `op_i * op_i` as unsigned integers.
- R2: Bit 0 of `sq_o` always equals bit 0 of `op_i`.
- R3: Bit 1 of `sq_o` is always 0.
- R4: The low W/2 bits of `sq_o` depend only on the low half of the operand: they equal the low W/2 bits of (`op_i[W/2-1:0]`)².
- R5: The final addition that forms the top W result bits never carries out of bit 2W-1. For the all-ones operand the result is 2^(2W) - 2^(W+1) + 1.
- R6: For W of 16 and 32 the result is exact for the zero operand, the all-ones operand, every single-bit operand 2^k (result 2^(2k)) and random operands.
- R7: When either half of the operand is zero, the cross term is zero. The result is then the square of the low half, or the square of the high half shifted left by W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | W | Unsigned operand |
| sq_o | output | 2*W | Unsigned square of the operand |

## Verification
The bench instantiates the block four times, with W set to 4, 8, 16 and 32, and drives all four in the same step. At 4 and 8 bits every operand value is applied, so the bit-level rules and the no-carry rule are covered completely at the two smallest recursion depths. At 16 and 32 bits the operands are 100000 random values plus the zero, all-ones, single-bit and zero-half patterns. These reach the deepest recursion, where the carries between recursion levels are longest.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // Legal operand width: a power of two, at least 4 and at most 32.
    function automatic bit width_ok(int w);
        return (w >= 4) && (w <= 32) && ((w & (w - 1)) == 0);
    endfunction

endpackage

// File: rtl/mul_node.sv
// Recursive half-width multiplier: W x W -> 2W, vertical-and-crosswise split.
module mul_node #(
    parameter int W = 2
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);

    if (W == 2) begin : g_leaf
        logic [3:0] p_d;
        logic       c1_d;
        always_comb begin
            p_d[0] = a_i[0] & b_i[0];
            p_d[1] = (a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1]);
            c1_d   = (a_i[1] & b_i[0]) & (a_i[0] & b_i[1]);
            p_d[2] = (a_i[1] & b_i[1]) ^ c1_d;
            p_d[3] = (a_i[1] & b_i[1]) & c1_d;
        end
        assign p_o = p_d;
    end else begin : g_split
        localparam int H = W / 2;

        logic [W-1:0]   ll_d, lh_d, hl_d, hh_d;
        logic [W:0]     mid_d;
        logic [2*W-1:0] mid_ext_d;
        logic [2*W-1:0] p_d;

        mul_node #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(ll_d));
        mul_node #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(lh_d));
        mul_node #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(hl_d));
        mul_node #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(hh_d));

        always_comb begin
            mid_d     = {1'b0, lh_d} + {1'b0, hl_d};
            mid_ext_d = {{(W-1){1'b0}}, mid_d} << H;
            p_d       = {hh_d, ll_d} + mid_ext_d;
        end
        assign p_o = p_d;
    end

    // A zero factor must give a zero product.
    always_comb begin
        if ((a_i == '0) || (b_i == '0)) begin
            AST_MUL_ZERO: assert (p_o == '0) else $error("zero factor, nonzero product"); // R7
        end
    end

endmodule

// File: rtl/sqr_node.sv
// Recursive squarer: two half-width squarers, one half-width multiplier,
// cross term doubled by a one-place wire shift.
module sqr_node #(
    parameter int W = 2
) (
    input  logic [W-1:0]   a_i,
    output logic [2*W-1:0] sq_o
);

    if (W == 2) begin : g_leaf
        logic       and_d;
        logic [3:0] sq_d;
        always_comb begin
            and_d   = a_i[1] & a_i[0];
            sq_d[0] = a_i[0];
            sq_d[1] = 1'b0;
            sq_d[2] = a_i[1] ^ and_d;   // half adder sum
            sq_d[3] = a_i[1] & and_d;   // half adder carry
        end
        assign sq_o = sq_d;
    end else begin : g_split
        localparam int H = W / 2;

        logic [W-1:0]   sq_lo_d, sq_hi_d, cross_d;
        logic [W:0]     dbl_d;
        logic [W+1:0]   mid_d;
        logic [W:0]     top_d;
        logic [2*W-1:0] sq_d;

        sqr_node #(.W(H)) u_sq_lo (.a_i(a_i[H-1:0]), .sq_o(sq_lo_d));
        sqr_node #(.W(H)) u_sq_hi (.a_i(a_i[W-1:H]), .sq_o(sq_hi_d));
        mul_node #(.W(H)) u_cross (.a_i(a_i[W-1:H]), .b_i(a_i[H-1:0]), .p_o(cross_d));

        always_comb begin
            dbl_d = {cross_d, 1'b0};
            mid_d = {1'b0, dbl_d} + {{(W+2-H){1'b0}}, sq_lo_d[W-1:H]};
            top_d = {1'b0, sq_hi_d} + {{(H-1){1'b0}}, mid_d[W+1:H]};
            sq_d  = {top_d[W-1:0], mid_d[H-1:0], sq_lo_d[H-1:0]};
        end
        assign sq_o = sq_d;

        always_comb begin
            AST_NO_OVERFLOW: assert (top_d[W] == 1'b0) else $error("top add carried out"); // R5
            AST_LO_BIT0: assert (sq_lo_d[0] == a_i[0]) else $error("low square bit0 mismatch"); // R2
            AST_LO_BIT1: assert (sq_lo_d[1] == 1'b0) else $error("low square bit1 set"); // R3
            AST_HI_BIT1: assert (sq_hi_d[1] == 1'b0) else $error("high square bit1 set"); // R3
            if (a_i[W-1:H] == '0) begin
                AST_CROSS_ZERO: assert (cross_d == '0) else $error("cross term nonzero"); // R7
            end
        end
    end

endmodule

// File: rtl/dc_squarer.sv
module dc_squarer #(
    parameter int W = 8
) (
    input  logic [W-1:0]   op_i,
    output logic [2*W-1:0] sq_o
);

    if (!sq_pkg::width_ok(W)) begin : g_bad_width
        $error("dc_squarer: W must be a power of two from 4 to 32");
    end

    logic [2*W-1:0] sq_d;

    sqr_node #(.W(W)) u_root (.a_i(op_i), .sq_o(sq_d));

    assign sq_o = sq_d;

    always_comb begin
        AST_OUT_BIT0: assert (sq_d[0] == op_i[0]) else $error("result bit0 mismatch"); // R2
        AST_OUT_BIT1: assert (sq_d[1] == 1'b0) else $error("result bit1 set"); // R3
    end

endmodule

// File: tb/dc_squarer_bench.sv
`timescale 1ns/100ps
module dc_squarer_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [3:0]  op4;
    logic [7:0]  op8;
    logic [15:0] op16;
    logic [31:0] op32;
    logic [7:0]  sq4;
    logic [15:0] sq8;
    logic [31:0] sq16;
    logic [63:0] sq32;

    dc_squarer #(.W(4))  u_dc_squarer_w4  (.op_i(op4),  .sq_o(sq4));
    dc_squarer #(.W(8))  u_dc_squarer_w8  (.op_i(op8),  .sq_o(sq8));
    dc_squarer #(.W(16)) u_dc_squarer_w16 (.op_i(op16), .sq_o(sq16));
    dc_squarer #(.W(32)) u_dc_squarer     (.op_i(op32), .sq_o(sq32));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] sqr(input logic [63:0] v);
        return v * v;
    endfunction

    task automatic apply(input logic [31:0] v4, input logic [31:0] v8,
                         input logic [31:0] v16, input logic [31:0] v32);
        op4  = v4[3:0];
        op8  = v8[7:0];
        op16 = v16[15:0];
        op32 = v32;
        #1;
    endtask

    task automatic chk_all();
        chk("R1 w4",  {56'd0, sq4},  sqr({60'd0, op4}));
        chk("R1 w8",  {48'd0, sq8},  sqr({56'd0, op8}));
        chk("R6 w16", {32'd0, sq16}, sqr({48'd0, op16}));
        chk("R6 w32", sq32,          sqr({32'd0, op32}));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!done && cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Initial state: zero operand gives zero on every width.
        apply(0, 0, 0, 0);
        chk("R1 zero w8",  {48'd0, sq8}, 64'd0);
        chk("R6 zero w32", sq32,         64'd0);

        // Exhaustive at W=4 and W=8, random at 16 and 32.
        for (int i = 0; i < 100000; i++) begin
            logic [31:0] r8;
            r8 = (i < 65536) ? i : $urandom;
            apply(i, r8, $urandom, $urandom);
            chk_all();
            chk("R2 bit0 w32", {63'd0, sq32[0]}, {63'd0, op32[0]});
            chk("R3 bit1 w32", {63'd0, sq32[1]}, 64'd0);
            chk("R2 bit0 w8",  {63'd0, sq8[0]},  {63'd0, op8[0]});
            chk("R3 bit1 w8",  {63'd0, sq8[1]},  64'd0);
            chk("R4 low half w8",  {60'd0, sq8[3:0]},   {60'd0, sqr({60'd0, op8[3:0]})    & 64'hF});
            chk("R4 low half w32", {48'd0, sq32[15:0]}, {48'd0, sqr({48'd0, op32[15:0]}) & 64'hFFFF});
        end

        // All-ones operands: no carry out of the top addition.
        apply(32'hF, 32'hFF, 32'hFFFF, 32'hFFFF_FFFF);
        chk("R5 ones w4",  {56'd0, sq4},  64'd225);
        chk("R5 ones w8",  {48'd0, sq8},  64'd65025);
        chk("R5 ones w16", {32'd0, sq16}, 64'hFFFE_0001);
        chk("R5 ones w32", sq32,          64'hFFFF_FFFE_0000_0001);

        // Single-bit operands.
        for (int k = 0; k < 32; k++) begin
            logic [63:0] e;
            e = 64'd1 << (2 * k);
            apply(0, 0, (k < 16) ? (32'd1 << k) : 32'd0, 32'd1 << k);
            chk("R6 onehot w32", sq32, e);
            if (k < 16) chk("R6 onehot w16", {32'd0, sq16}, e);
        end

        // One half zero: no cross contribution.
        for (int j = 1; j < 64; j++) begin
            logic [15:0] h;
            h = 16'($urandom) | 16'd1;
            apply(0, 0, 0, {16'd0, h});
            chk("R7 hi zero w32", sq32, sqr({48'd0, h}));
            apply(0, 0, 0, {h, 16'd0});
            chk("R7 lo zero w32", sq32, sqr({48'd0, h}) << 32);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule